// File: doc/BRIEF.md
# Multichannel Serial Input Port

This block collects serial audio-style streams from a set of independent input channels and merges them into one shared word queue that a host drains. Each channel brings its own bit clock, frame sync and data line. All of them are asynchronous to the system clock. The block passes them through synchronizers and detects the rising edges of the bit clock in the system clock domain. It then assembles each channel's 64-bit frame into two 32-bit words. A round-robin arbiter moves completed words into a common queue of 32-bit words with eight entries.

The host sees the queue through empty, full and fill-count flags and a pop strobe. If a word arrives while the queue is full, the word is discarded and a sticky overflow flag is raised. The host clears that flag with a one-cycle pulse. A per-channel enable mask removes channels from service. In an optional mode, channel 0 becomes a 20-bit parallel capture path that takes one word on each rising edge of its clock. The other channels stay serial.

Top module: `sinp_top`

## Requirements
- R1: After reset, empty is 1, full is 0, fill is 0 and ovf is 0.
- R2: A frame starts at a bit-clock rising edge on which frame sync is high. That bit and the 63 bits on the following rising edges form a 64-bit frame, received most significant bit first. The first 32 bits received form word 1 and the last 32 bits form word 2. Word 1 enters the queue before word 2.
- R3: A word granted while the queue is full and no pop is accepted is discarded, and the queue contents are unchanged. The discard sets ovf, and ovf stays set until a cycle with ovf_clr high and no new discard.
- R4: The queue holds 8 words. fill counts the stored words from 0 to 8, full is 1 exactly at 8, and empty is 1 exactly at 0.
- R5: A pop on a non-empty queue places the oldest word on rd_data one cycle later. A pop on an empty queue leaves rd_data, fill and empty unchanged.
- R6: When several channels hold a completed word, the arbiter grants one word per system cycle. The search starts at the channel after the one granted last, and starts at channel 0 after reset.
- R7: A channel whose chan_en bit is 0 never writes the queue, and its frame assembly is held cleared.
- R8: With par_mode high, each rising edge of channel 0's clock captures par_data as one word in bits 19:0, with bits 31:20 zero. Channels 1 to 7 keep their serial behaviour.
- R9: A word that arrives in the same cycle as an accepted pop on a full queue is stored. fill stays 8 and ovf is not set.
- R10: A frame sync seen partway through a frame restarts the frame, and the partial bits are discarded. Bits that follow a completed frame without a new frame sync are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | NCH | Per-channel enable mask |
| par_mode | input | 1 | Selects parallel capture on channel 0 |
| bclk | input | NCH | Per-channel bit clock (asynchronous) |
| fsync | input | NCH | Per-channel frame sync (asynchronous) |
| sdata | input | NCH | Per-channel serial data (asynchronous) |
| par_data | input | PAR_W | Parallel capture bus for channel 0 |
| pop | input | 1 | Host pop strobe |
| ovf_clr | input | 1 | Host clear of the overflow flag |
| rd_data | output | WORD_W | Word popped on the previous cycle |
| empty | output | 1 | Queue holds no word |
| full | output | 1 | Queue holds FIFO_DEPTH words |
| fill | output | clog2(FIFO_DEPTH+1) | Number of stored words |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The case that needs the most care is a push and a pop in the same cycle while the queue is full. In that cycle the full check and the pop interact, and a wrong ordering either drops the word or corrupts the oldest entry. The bench fills the queue with eight second-half words. It then raises channel 0's clock in parallel mode and asserts pop exactly three system cycles later, so the new word reaches the queue in the cycle of the pop. The result is judged by fill staying at 8, ovf staying clear, the popped word being the oldest one, and the parallel word coming out last after the remaining seven.

// File: rtl/sinp_pkg.sv
package sinp_pkg;

   localparam int SINP_WORD_W = 32;
   localparam int SINP_SYNC_STAGES = 2;

   // next index in a ring of n positions
   function automatic int wrap_inc(input int v, input int n);
      return (v + 1 >= n) ? 0 : v + 1;
   endfunction

endpackage

// File: rtl/sinp_sync.sv
module sinp_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sinp_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/sinp_deser.sv
module sinp_deser #(
   parameter int WORD_W = 32,
   parameter int PAR_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              par_sel,
   input  logic              rise,
   input  logic              fs,
   input  logic              sd,
   input  logic [PAR_W-1:0]  par_in,
   input  logic              gnt,
   output logic              pend,
   output logic [WORD_W-1:0] word
);

   localparam int FRAME_W = 2 * WORD_W;
   localparam int BCNT_W  = $clog2(FRAME_W + 1);
   localparam logic [BCNT_W-1:0] HALF_CNT = BCNT_W'(WORD_W);
   localparam logic [BCNT_W-1:0] FULL_CNT = BCNT_W'(FRAME_W);

   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] shnext;
   logic [BCNT_W-1:0] bcnt;
   logic [BCNT_W-1:0] bnext;
   logic              armed;

   assign shnext = {shreg[WORD_W-2:0], sd};
   assign bnext  = bcnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         bcnt  <= '0;
         armed <= 1'b0;
         pend  <= 1'b0;
         word  <= '0;
      end else if (!en) begin
         bcnt  <= '0;
         armed <= 1'b0;
         pend  <= 1'b0;
      end else begin
         if (gnt) pend <= 1'b0;
         if (rise) begin
            if (par_sel) begin
               word <= WORD_W'(par_in);
               pend <= 1'b1;
            end else if (fs) begin
               // frame start: this bit is the first of the frame
               shreg <= WORD_W'(sd);
               bcnt  <= BCNT_W'(1);
               armed <= 1'b1;
            end else if (armed) begin
               shreg <= shnext;
               bcnt  <= bnext;
               if (bnext == HALF_CNT) begin
                  word <= shnext;
                  pend <= 1'b1;
               end
               if (bnext == FULL_CNT) begin
                  word  <= shnext;
                  pend  <= 1'b1;
                  armed <= 1'b0;
                  bcnt  <= '0;
               end
            end
         end
      end
   end

endmodule

// File: rtl/sinp_rr_arb.sv
module sinp_rr_arb #(
   parameter int N = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         req,
   output logic [N-1:0]         gnt,
   output logic                 valid,
   output logic [$clog2(N)-1:0] idx
);

   localparam int IDX_W = $clog2(N);

   logic [IDX_W-1:0] ptr;
   logic             found;

   always_comb begin
      gnt   = '0;
      idx   = '0;
      found = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (!found && req[(int'(ptr) + i) % N]) begin
            found = 1'b1;
            gnt[(int'(ptr) + i) % N] = 1'b1;
            idx = IDX_W'((int'(ptr) + i) % N);
         end
      end
      valid = found;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr <= '0;
      else if (valid) ptr <= IDX_W'(sinp_pkg::wrap_inc(int'(idx), N));
   end

endmodule

// File: rtl/sinp_fifo.sv
module sinp_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic [W-1:0]             wdata,
   input  logic                     pop,
   output logic [W-1:0]             rdata,
   output logic                     full,
   output logic                     empty,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                     drop
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] rd_ptr;
   logic          pop_ok;
   logic          push_ok;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop_ok);
   assign drop    = push && !push_ok;

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         rdata  <= '0;
      end else begin
         if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (pop_ok) begin
            rdata  <= mem[rd_ptr];
            rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         end
         if (push_ok && !pop_ok)      count <= count + 1'b1;
         else if (pop_ok && !push_ok) count <= count - 1'b1;
      end
   end

endmodule

// File: rtl/sinp_top.sv
module sinp_top #(
   parameter int NCH         = 8,
   parameter int WORD_W      = sinp_pkg::SINP_WORD_W,
   parameter int FIFO_DEPTH  = 8,
   parameter int PAR_W       = 20,
   parameter int SYNC_STAGES = sinp_pkg::SINP_SYNC_STAGES
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NCH-1:0]                  chan_en,
   input  logic                            par_mode,
   input  logic [NCH-1:0]                  bclk,
   input  logic [NCH-1:0]                  fsync,
   input  logic [NCH-1:0]                  sdata,
   input  logic [PAR_W-1:0]                par_data,
   input  logic                            pop,
   input  logic                            ovf_clr,
   output logic [WORD_W-1:0]               rd_data,
   output logic                            empty,
   output logic                            full,
   output logic [$clog2(FIFO_DEPTH+1)-1:0] fill,
   output logic                            ovf
);

   localparam int IDX_W = $clog2(NCH);

   if (NCH < 2) begin : g_bad_nch
      $error("sinp_top: NCH must be at least 2");
   end
   if (WORD_W < 2) begin : g_bad_word
      $error("sinp_top: WORD_W must be at least 2");
   end
   if (PAR_W < 1 || PAR_W > WORD_W) begin : g_bad_par
      $error("sinp_top: PAR_W must be in 1..WORD_W");
   end
   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("sinp_top: FIFO_DEPTH must be at least 2");
   end

   logic [NCH-1:0]    ch_rise;
   logic [NCH-1:0]    ch_pend;
   logic [WORD_W-1:0] ch_word [NCH];
   logic [NCH-1:0]    arb_gnt;
   logic              arb_valid;
   logic [IDX_W-1:0]  arb_idx;
   logic [WORD_W-1:0] push_word;
   logic              fifo_drop;
   logic              par_mode_s;
   logic [PAR_W-1:0]  par_s;

   sinp_sync #(.W(PAR_W + 1), .STAGES(SYNC_STAGES)) u_psync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({par_mode, par_data}),
      .q     ({par_mode_s, par_s})
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [2:0]       sy;
      logic             clk_d;
      logic             psel;
      logic [PAR_W-1:0] pin;

      sinp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     ({bclk[c], fsync[c], sdata[c]}),
         .q     (sy)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) clk_d <= 1'b0;
         else        clk_d <= sy[2];
      end

      assign ch_rise[c] = sy[2] & ~clk_d;

      if (c == 0) begin : g_par
         assign psel = par_mode_s;
         assign pin  = par_s;
      end else begin : g_ser
         assign psel = 1'b0;
         assign pin  = '0;
      end

      sinp_deser #(.WORD_W(WORD_W), .PAR_W(PAR_W)) u_deser (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (chan_en[c]),
         .par_sel (psel),
         .rise    (ch_rise[c]),
         .fs      (sy[1]),
         .sd      (sy[0]),
         .par_in  (pin),
         .gnt     (arb_gnt[c]),
         .pend    (ch_pend[c]),
         .word    (ch_word[c])
      );
   end

   sinp_rr_arb #(.N(NCH)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (ch_pend & chan_en),
      .gnt   (arb_gnt),
      .valid (arb_valid),
      .idx   (arb_idx)
   );

   assign push_word = ch_word[arb_idx];

   sinp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (arb_valid),
      .wdata (push_word),
      .pop   (pop),
      .rdata (rd_data),
      .full  (full),
      .empty (empty),
      .count (fill),
      .drop  (fifo_drop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ovf <= 1'b0;
      else if (fifo_drop) ovf <= 1'b1;
      else if (ovf_clr)   ovf <= 1'b0;
   end

endmodule

// File: rtl/sinp_checker.sv
module sinp_checker #(
   parameter int NCH    = 8,
   parameter int WORD_W = 32,
   parameter int DEPTH  = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        pop,
   input logic                        ovf_clr,
   input logic                        empty,
   input logic                        full,
   input logic [$clog2(DEPTH+1)-1:0]  fill,
   input logic                        ovf,
   input logic [WORD_W-1:0]           rd_data,
   input logic [NCH-1:0]              gnt,
   input logic [NCH-1:0]              chan_en,
   input logic                        push_valid
);

   localparam int CW = $clog2(DEPTH + 1);

   assert_full_not_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !empty);

   assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CW'(DEPTH));

   assert_fill_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (fill == $past(fill)) || (fill == $past(fill) + 1'b1)
               || (fill == $past(fill) - 1'b1));

   assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf);

   assert_ovf_on_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && full && !pop) |=> ovf);

   assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty) |=> $stable(rd_data));

   assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~chan_en) == '0);

   assert_pop_push_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (full && pop && push_valid) |=> full);

endmodule

bind sinp_top sinp_checker #(.NCH(NCH), .WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pop        (pop),
   .ovf_clr    (ovf_clr),
   .empty      (empty),
   .full       (full),
   .fill       (fill),
   .ovf        (ovf),
   .rd_data    (rd_data),
   .gnt        (arb_gnt),
   .chan_en    (chan_en),
   .push_valid (arb_valid)
);

// File: tb/sinp_top_test.sv
`timescale 1ns/1ps
module sinp_top_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  chan_en, bclk, fsync, sdata;
   logic        par_mode, pop, ovf_clr;
   logic [19:0] par_data;
   logic [31:0] rd_data;
   logic        empty, full, ovf;
   logic [3:0]  fill;

   logic [63:0] fd [8];
   int          rr;
   int          nchk = 0;
   int          nfail = 0;

   always #2.5 clk = ~clk;

   sinp_top uut (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .par_mode(par_mode),
      .bclk(bclk), .fsync(fsync), .sdata(sdata), .par_data(par_data),
      .pop(pop), .ovf_clr(ovf_clr), .rd_data(rd_data), .empty(empty),
      .full(full), .fill(fill), .ovf(ovf)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic send_bits(input logic [7:0] m, input int first, input int n);
      for (int b = first; b < first + n; b++) begin
         for (int c = 0; c < 8; c++) if (m[c]) begin
            fsync[c] = (b == 0);
            sdata[c] = fd[c][63-b];
         end
         tick(4);
         bclk = bclk | m;
         tick(4);
         bclk = bclk & ~m;
      end
      for (int c = 0; c < 8; c++) if (m[c]) fsync[c] = 1'b0;
      tick(12);
   endtask

   task automatic pop_expect(input string tag, input logic [31:0] exp);
      pop = 1'b1;
      tick(1);
      pop = 1'b0;
      check_eq(tag, rd_data, exp);
   endtask

   task automatic par_strobe(input logic [19:0] v);
      par_data = v;
      tick(4);
      bclk[0] = 1'b1;
      tick(4);
      bclk[0] = 1'b0;
      tick(12);
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog expired: actual running expected done");
      report();
      $finish;
   end

   initial begin
      for (int c = 0; c < 8; c++)
         fd[c] = {32'h1357_0000 + 32'(c) * 32'h0101_0011,
                  32'hF0E0_1234 ^ (32'(c) * 32'h0003_0307)};
      rst_n = 1'b0; chan_en = 8'hFF; bclk = '0; fsync = '0; sdata = '0;
      par_mode = 1'b0; pop = 1'b0; ovf_clr = 1'b0; par_data = '0;
      rr = 0;
      tick(5);
      rst_n = 1'b1;
      tick(3);

      // R1 reset state
      check_eq("R1 empty", 32'(empty), 32'd1);
      check_eq("R1 full", 32'(full), 32'd0);
      check_eq("R1 fill", 32'(fill), 32'd0);
      check_eq("R1 ovf", 32'(ovf), 32'd0);

      // R2 sweep: each channel alone, one frame
      for (int c = 0; c < 8; c++) begin
         send_bits(8'(1 << c), 0, 64);
         check_eq("R2 fill after frame", 32'(fill), 32'd2);
         pop_expect("R2 first word", fd[c][63:32]);
         pop_expect("R2 second word", fd[c][31:0]);
         rr = (c + 1) % 8;
      end

      // R10 partial frame restart, trailing bits ignored (channel 2)
      send_bits(8'h04, 0, 10);
      send_bits(8'h04, 0, 64);
      send_bits(8'h04, 1, 40);
      check_eq("R10 fill", 32'(fill), 32'd2);
      pop_expect("R10 first word", fd[2][63:32]);
      pop_expect("R10 second word", fd[2][31:0]);
      rr = 3;

      // R6 / R4: all channels in lockstep, first halves
      send_bits(8'hFF, 0, 32);
      check_eq("R4 full at 8", 32'(full), 32'd1);
      check_eq("R4 fill 8", 32'(fill), 32'd8);
      check_eq("R4 not empty", 32'(empty), 32'd0);
      for (int i = 0; i < 8; i++)
         pop_expect("R6 round-robin order", fd[(rr + i) % 8][63:32]);
      check_eq("R4 empty after drain", 32'(empty), 32'd1);

      // second halves fill the queue; then a further round is dropped
      send_bits(8'hFF, 32, 32);
      check_eq("R4 full again", 32'(fill), 32'd8);
      check_eq("R3 no ovf yet", 32'(ovf), 32'd0);
      send_bits(8'hFF, 0, 32);
      check_eq("R3 ovf set", 32'(ovf), 32'd1);
      check_eq("R3 fill unchanged", 32'(fill), 32'd8);
      ovf_clr = 1'b1;
      tick(1);
      ovf_clr = 1'b0;
      tick(1);
      check_eq("R3 ovf cleared", 32'(ovf), 32'd0);

      // R9 push and pop in one cycle on a full queue
      par_mode = 1'b1;
      par_data = 20'hA5C3E;
      tick(8);
      bclk[0] = 1'b1;
      tick(3);
      pop = 1'b1;
      tick(1);
      pop = 1'b0;
      check_eq("R9 oldest popped", rd_data, fd[rr][31:0]);
      tick(3);
      bclk[0] = 1'b0;
      tick(8);
      check_eq("R9 fill stays 8", 32'(fill), 32'd8);
      check_eq("R9 no ovf", 32'(ovf), 32'd0);
      for (int i = 1; i < 8; i++)
         pop_expect("R3 kept word", fd[(rr + i) % 8][31:0]);
      pop_expect("R9 parallel word last", {12'h000, 20'hA5C3E});
      rr = 1;

      // R8 parallel capture sweep
      for (int i = 0; i < 4; i++) begin
         par_strobe(20'(i * 32'h2A5C3 + 32'h00F0F));
         pop_expect("R8 parallel word", 32'(20'(i * 32'h2A5C3 + 32'h00F0F)));
      end
      send_bits(8'h02, 0, 64);
      check_eq("R8 serial ch1 fill", 32'(fill), 32'd2);
      pop_expect("R8 ch1 first word", fd[1][63:32]);
      pop_expect("R8 ch1 second word", fd[1][31:0]);
      par_mode = 1'b0;
      tick(8);

      // R7 disabled channel
      chan_en = 8'hDF;
      send_bits(8'h20, 0, 64);
      check_eq("R7 fill zero", 32'(fill), 32'd0);
      check_eq("R7 empty", 32'(empty), 32'd1);
      chan_en = 8'hFF;
      tick(8);
      check_eq("R7 no stale word", 32'(fill), 32'd0);

      // R5 pop on empty queue
      begin
         logic [31:0] prev;
         prev = rd_data;
         pop = 1'b1;
         tick(1);
         pop = 1'b0;
         tick(1);
         check_eq("R5 rd_data held", rd_data, prev);
         check_eq("R5 fill held", 32'(fill), 32'd0);
         check_eq("R5 empty held", 32'(empty), 32'd1);
      end

      report();
      $finish;
   end

endmodule